// File: doc/BRIEF.md
# ADC Conversion Sequencer with Selection Lock

This block is the digital control for a 10-bit successive-approximation converter. It runs in the converter's own clock domain. A host register interface gives it an enable level, a free-running mode level and a start write strobe. The block produces a sample-and-hold strobe and a trial code for the external DAC. It reads back one comparator decision per bit cycle and stores the finished code in a high/low result pair. At the end of each conversion it raises a completion flag. The flag stays set until the host writes a one to clear it.

Channel and reference selection written by the host goes into a shadow register first. A live copy, which drives the analog multiplexer, follows the shadow only while no conversion is running. The live copy locks at the start edge, so a host write cannot disturb the sampling window. It follows the shadow again in the final cycle of the conversion. In free-running mode the next conversion starts on the completion edge. That conversion uses whatever selection the live copy captured on that edge.

The first conversion after the block is enabled takes the extended timing. Clearing the enable aborts any conversion and arms that extended timing again.

Top module: `adc_sar_sequencer`

## Requirements
- R1: After reset, busy, doneFlag, sampleHold, liveSel, resHi and resLo are all zero.
- R2: While idle, a selection written on one edge reaches liveSel on the following edge.
- R3: liveSel keeps its value from the start edge through the final conversion cycle. A selection written during a conversion appears on liveSel on the completion edge and not before.
- R4: A start write while enabled and idle begins a conversion on the next edge, and busy is high from then until completion. A start write while disabled leaves busy low.
- R5: A normal conversion completes 13 edges after its start edge. sampleHold is high for exactly one cycle, the second cycle of the conversion.
- R6: The first conversion after enable completes 25 edges after its start edge, with sampleHold high in cycle 14.
- R7: Bits are decided MSB first, one per cycle after the hold cycle. A comparator input of 1 means the analog input is at least dacCode, and the trial bit is then kept. For an ideal comparator the result equals the input code, over the whole range 0 to 1023.
- R8: On completion, resHi holds result bits [9:8] and resLo holds bits [7:0].
- R9: doneFlag is set on the completion edge and stays set until flagClrWr is high at an edge.
- R10: With freeRun and enable both high, the next normal conversion starts on the completion edge. busy stays high, and liveSel captured on that edge stays frozen through the new conversion.
- R11: Clearing enable drops busy on the next edge, and the aborted conversion never sets doneFlag. The next conversion uses the 25-cycle timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Converter enable level |
| freeRun | input | 1 | Free-running mode level |
| startWr | input | 1 | Host writes the start bit (one-cycle strobe) |
| flagClrWr | input | 1 | Host writes one to the completion flag |
| selWr | input | 1 | Host writes the selection shadow |
| selData | input | 5 | Channel/reference selection value |
| cmpIn | input | 1 | Comparator decision: analog input >= dacCode |
| busy | output | 1 | Start bit readback; high during a conversion |
| doneFlag | output | 1 | Completion flag |
| sampleHold | output | 1 | Sample-and-hold strobe |
| dacCode | output | 10 | Trial code for the DAC |
| liveSel | output | 5 | Live selection driving the multiplexer |
| resHi | output | 2 | Result MSBs |
| resLo | output | 8 | Result LSBs |

## Verification
Every timing claim is counted in edges from the start edge, which is the first rising edge that sees startWr high. The hold strobe is due one edge after the start edge for a normal conversion and thirteen edges after it for an extended one. The result and the flag are due 13 or 25 edges after the start edge, and a released selection appears on that same completion edge. The driver stamps each expected result with the edge index at which it must appear. The monitor compares both the value and that index when the flag rises. Level checks are taken at the falling edge that follows the counted rising edge, so a check that lands one edge early or one edge late reads a different value.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int RES_BITS = 10;
  localparam int IDX_W    = $clog2(RES_BITS);

  typedef struct packed {
    logic             sarClear;
    logic             bitEn;
    logic [IDX_W-1:0] bitIdx;
    logic             commit;
    logic             selFollow;
  } seqStrobe_t;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int RES_W     = RES_BITS,
  parameter int NORM_HOLD = 2,
  parameter int EXT_HOLD  = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       freeRun,
  input  logic       startWr,
  input  logic       flagClrWr,
  output logic       busy,
  output logic       doneFlag,
  output logic       sampleHold,
  output seqStrobe_t strb
);
  localparam int EXT_LAST = EXT_HOLD + RES_W + 1;
  localparam int CNT_W    = $clog2(EXT_LAST + 1);

  logic [CNT_W-1:0] cyc, holdCyc, lastCyc, bitPos;
  logic extMode, firstPend;
  logic startNow, lastNow, chainNow, inBits;

  always_comb begin
    holdCyc  = extMode ? CNT_W'(EXT_HOLD) : CNT_W'(NORM_HOLD);
    lastCyc  = holdCyc + CNT_W'(RES_W + 1);
    startNow = enable && !busy && startWr;
    lastNow  = busy && (cyc == lastCyc);
    chainNow = lastNow && enable && freeRun;
    inBits   = busy && (cyc > holdCyc) && (cyc < lastCyc);
    bitPos   = cyc - holdCyc - CNT_W'(1);
    sampleHold = busy && (cyc == holdCyc);
    strb.sarClear  = startNow || chainNow;
    strb.bitEn     = inBits;
    strb.bitIdx    = IDX_W'(CNT_W'(RES_W - 1) - bitPos);
    strb.commit    = lastNow && enable;
    strb.selFollow = !busy || lastNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cyc       <= '0;
      extMode   <= 1'b0;
      firstPend <= 1'b1;
      doneFlag  <= 1'b0;
    end else begin
      if (!enable) begin
        busy      <= 1'b0;
        cyc       <= '0;
        firstPend <= 1'b1;
      end else if (startNow) begin
        busy      <= 1'b1;
        cyc       <= CNT_W'(1);
        extMode   <= firstPend;
        firstPend <= 1'b0;
      end else if (lastNow) begin
        extMode <= 1'b0;
        if (freeRun) begin
          cyc <= CNT_W'(1);
        end else begin
          busy <= 1'b0;
          cyc  <= '0;
        end
      end else if (busy) begin
        cyc <= cyc + CNT_W'(1);
      end

      if (lastNow && enable) doneFlag <= 1'b1;
      else if (flagClrWr)    doneFlag <= 1'b0;
    end
  end

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> busy);
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!busy && !sampleHold));
  assert_hold_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |=> !sampleHold);
  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lastNow && enable) |=> (doneFlag && (busy == $past(freeRun))));
endmodule

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int RES_W = RES_BITS,
  parameter int LO_W  = 8,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             selWr,
  input  logic [SEL_W-1:0] selData,
  input  logic             cmpIn,
  output logic [RES_W-1:0] dacCode,
  output logic [SEL_W-1:0] liveSel,
  output logic [RES_W-LO_W-1:0] resHi,
  output logic [LO_W-1:0]  resLo
);
  localparam int HI_W = RES_W - LO_W;

  logic [RES_W-1:0] sar, trialBit, lowMask;
  logic [SEL_W-1:0] shadowSel;

  always_comb begin
    trialBit = RES_W'(1) << strb.bitIdx;
    lowMask  = trialBit | (trialBit - RES_W'(1));
    dacCode  = strb.bitEn ? (sar | trialBit) : sar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sar <= '0;
    end else if (strb.sarClear) begin
      sar <= '0;
    end else if (strb.bitEn && cmpIn) begin
      sar <= sar | trialBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHi <= '0;
      resLo <= '0;
    end else if (strb.commit) begin
      resHi <= sar[RES_W-1 -: HI_W];
      resLo <= sar[LO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowSel <= '0;
      liveSel   <= '0;
    end else begin
      if (selWr)          shadowSel <= selData;
      if (strb.selFollow) liveSel   <= shadowSel;
    end
  end

  assert_low_bits_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitEn |-> ((sar & lowMask) == '0));
  assert_live_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitEn |=> $stable(liveSel));
endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
  import adcseq_pkg::*;
#(
  parameter int RES_W     = RES_BITS,
  parameter int LO_W      = 8,
  parameter int SEL_W     = 5,
  parameter int NORM_HOLD = 2,
  parameter int EXT_HOLD  = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic                   freeRun,
  input  logic                   startWr,
  input  logic                   flagClrWr,
  input  logic                   selWr,
  input  logic [SEL_W-1:0]       selData,
  input  logic                   cmpIn,
  output logic                   busy,
  output logic                   doneFlag,
  output logic                   sampleHold,
  output logic [RES_W-1:0]       dacCode,
  output logic [SEL_W-1:0]       liveSel,
  output logic [RES_W-LO_W-1:0]  resHi,
  output logic [LO_W-1:0]        resLo
);
  seqStrobe_t strb;

  adcseq_ctrl #(
    .RES_W(RES_W), .NORM_HOLD(NORM_HOLD), .EXT_HOLD(EXT_HOLD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
    .startWr(startWr), .flagClrWr(flagClrWr), .busy(busy),
    .doneFlag(doneFlag), .sampleHold(sampleHold), .strb(strb)
  );

  adcseq_datapath #(
    .RES_W(RES_W), .LO_W(LO_W), .SEL_W(SEL_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .selWr(selWr), .selData(selData),
    .cmpIn(cmpIn), .dacCode(dacCode), .liveSel(liveSel),
    .resHi(resHi), .resLo(resLo)
  );
endmodule

// File: tb/sim_adc_sar_sequencer.sv
module sim_adc_sar_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, enable, freeRun, startWr, flagClrWr, selWr, cmpIn;
  logic [4:0] selData;
  logic busy, doneFlag, sampleHold;
  logic [9:0] dacCode;
  logic [4:0] liveSel;
  logic [1:0] resHi;
  logic [7:0] resLo;

  int vin = 0;
  int cycCnt = 0;
  int nChecks = 0;
  int nFails = 0;
  logic manualClr = 1'b0;
  logic autoClrPulse = 1'b0;
  bit autoClr = 1'b1;
  logic prevDone = 1'b0;

  typedef struct {
    int val;
    int doneAt;
  } expItem_t;
  expItem_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  assign cmpIn = (vin >= int'(dacCode));
  always_comb flagClrWr = manualClr | autoClrPulse;

  adc_sar_sequencer u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
    .startWr(startWr), .flagClrWr(flagClrWr), .selWr(selWr),
    .selData(selData), .cmpIn(cmpIn), .busy(busy), .doneFlag(doneFlag),
    .sampleHold(sampleHold), .dacCode(dacCode), .liveSel(liveSel),
    .resHi(resHi), .resLo(resLo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at edge %0d", tag, act, exp, cycCnt);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setSel(input int v);
    selData = 5'(v);
    selWr = 1'b1;
    @(negedge clk);
    selWr = 1'b0;
  endtask

  // assumes a falling edge; returns at the falling edge after the start edge
  task automatic startConv(input int v, input bit ext, input bit push);
    vin = v;
    startWr = 1'b1;
    if (push) sbq.push_back('{v, cycCnt + 1 + (ext ? 25 : 13)});
    @(negedge clk);
    startWr = 1'b0;
  endtask

  // scoreboard monitor: value and completion edge (R5 R6 R7 R8 R9)
  always @(negedge clk) begin
    autoClrPulse = 1'b0;
    if (rstN && doneFlag && !prevDone) begin
      if (sbq.size() == 0) begin
        chk("R11 unexpected completion", 1, 0);
      end else begin
        expItem_t it;
        it = sbq.pop_front();
        chk("R7 R8 result", int'({resHi, resLo}), it.val);
        chk("R5 R6 completion edge", cycCnt, it.doneAt);
        if (autoClr) autoClrPulse = 1'b1;
      end
    end
    prevDone = doneFlag;
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; freeRun = 1'b0; startWr = 1'b0;
    selWr = 1'b0; selData = '0;
    tick(3);
    rstN = 1'b1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 doneFlag", int'(doneFlag), 0);
    chk("R1 sampleHold", int'(sampleHold), 0);
    chk("R1 liveSel", int'(liveSel), 0);
    chk("R1 result", int'({resHi, resLo}), 0);
    tick(1);

    // R2: idle follow, one edge behind the shadow
    setSel(5'h0A);
    chk("R2 live lags shadow", int'(liveSel), 0);
    tick(1);
    chk("R2 live follows", int'(liveSel), 5'h0A);

    // R4: start while disabled is ignored
    startConv(16, 1'b0, 1'b0);
    tick(1);
    chk("R4 disabled start busy", int'(busy), 0);
    chk("R4 disabled start flag", int'(doneFlag), 0);

    // R6 R3 R9: first conversion after enable is extended
    enable = 1'b1;
    autoClr = 1'b0;
    tick(1);
    startConv(10'h2A5, 1'b1, 1'b1);
    chk("R4 busy after start", int'(busy), 1);
    tick(13);
    chk("R6 hold in cycle 14", int'(sampleHold), 1);
    tick(1);
    chk("R6 hold single cycle", int'(sampleHold), 0);
    setSel(5'h13);
    chk("R3 frozen after write", int'(liveSel), 5'h0A);
    tick(9);
    chk("R3 frozen in final cycle", int'(liveSel), 5'h0A);
    chk("R4 busy in final cycle", int'(busy), 1);
    tick(1);
    chk("R3 released at completion", int'(liveSel), 5'h13);
    chk("R4 busy self-clears", int'(busy), 0);
    tick(3);
    chk("R9 flag held", int'(doneFlag), 1);
    manualClr = 1'b1;
    tick(1);
    manualClr = 1'b0;
    chk("R9 flag cleared by write", int'(doneFlag), 0);
    autoClr = 1'b1;

    // R5: normal conversion timing
    startConv(10'h0FF, 1'b0, 1'b1);
    tick(1);
    chk("R5 hold in cycle 2", int'(sampleHold), 1);
    tick(1);
    chk("R5 hold single cycle", int'(sampleHold), 0);
    tick(10);
    chk("R5 busy before completion", int'(busy), 1);
    tick(1);
    chk("R5 busy low at completion", int'(busy), 0);
    tick(2);

    // R7: range ends
    startConv(0, 1'b0, 1'b1);
    tick(15);
    startConv(1023, 1'b0, 1'b1);
    tick(15);

    // R10: free-running chain
    freeRun = 1'b1;
    startConv(10'h3C1, 1'b0, 1'b1);
    sbq.push_back('{10'h07E, cycCnt + 26});
    tick(4);
    setSel(5'h1F);
    chk("R3 frozen mid conversion", int'(liveSel), 5'h13);
    tick(8);
    chk("R10 chained busy", int'(busy), 1);
    chk("R10 live captured at completion", int'(liveSel), 5'h1F);
    vin = 10'h07E;
    freeRun = 1'b0;
    setSel(5'h04);
    tick(5);
    chk("R10 frozen in chained conversion", int'(liveSel), 5'h1F);
    tick(7);
    chk("R10 chain ends without freeRun", int'(busy), 0);
    chk("R3 released after chain", int'(liveSel), 5'h04);
    tick(2);

    // R11: abort and re-armed extended timing
    startConv(10'h200, 1'b0, 1'b0);
    tick(4);
    enable = 1'b0;
    tick(1);
    chk("R11 abort drops busy", int'(busy), 0);
    enable = 1'b1;
    tick(20);
    chk("R11 no flag after abort", int'(doneFlag), 0);
    startConv(10'h123, 1'b1, 1'b1);
    tick(13);
    chk("R11 extended after re-enable", int'(busy), 1);
    tick(14);

    chk("R7 all results seen", sbq.size(), 0);
    finishRun();
  end
endmodule